// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR4-style memory channel and walks the memory's reset, clock, clock-enable and on-die-termination pins through the ordered power-up procedure. A power-good input starts the sequence. The block first holds the memory in reset, then releases reset and waits for the memory's internal initialization. It then starts the memory clock and lets it settle. Next it raises clock-enable while presenting a deselect command, and it keeps clock-enable high through the combined DLL-lock and ZQ-calibration wait. When that wait has expired, a done flag rises and the command bus is handed to the rest of the controller.

Every delay is given in nanoseconds or in clock cycles and is converted to controller clock cycles by ceiling division against the clock period parameter. Each phase therefore lasts a whole number of cycles that is never shorter than required. A phase number is brought out so that the order of events can be observed. The zero-valued mode-register defaults that must be in force at reset are also presented on a fixed-layout output. If power-good drops at any moment, the block returns at once to the reset-held state.

Top module: `dram_pwrup_seq`

## Requirements
- R1: Phase codes are 0 off, 1 reset hold, 2 post-reset wait, 3 clock settle, 4 init wait, 5 ready. While the controller reset is asserted, or while power-good is low, phase is 0 and mem_reset_n, mem_ck_en, mem_cke, mem_odt, cmd_deselect and init_done are all 0.
- R2: On the first clock edge that samples power-good high in phase 0, the block enters phase 1. mem_reset_n stays low for exactly N_RST = ceil(RST_HOLD_NS*1000/CLK_PS) cycles and then rises.
- R3: mem_cke is low in phases 0 to 3 and is never high while mem_reset_n is low. It first goes high exactly N_POST + N_STAB cycles after mem_reset_n rises.
- R4: Phase 2 lasts exactly N_POST = ceil(POST_RST_NS*1000/CLK_PS) cycles, with mem_reset_n high and mem_ck_en low.
- R5: mem_ck_en rises on entry to phase 3 and stays high in phases 3 to 5. Phase 3 lasts N_STAB = max(ceil(CK_STAB_NS*1000/CLK_PS), CK_STAB_MIN) cycles.
- R6: cmd_deselect is high in phases 3 and 4, and so in the cycle in which mem_cke is first high. It is low in every other phase.
- R7: mem_cke stays high through phase 4, which lasts N_INIT = max(DLLK_CYC, ZQINIT_CYC) cycles. init_done then rises in phase 5, and mem_cke and init_done stay high while power-good stays high.
- R8: mem_odt is 0 before phase 4. On the edge entering phase 4 it takes the value odt_park AND NOT rtt_nom_en, so it is low whenever nominal termination is requested. It then holds that value unchanged through phases 4 and 5, whatever those inputs do later.
- R9: An edge that samples power-good low in any phase puts the block in phase 0 on the next cycle, with all outputs as in R1 and init_done cleared.
- R10: mr_dflt is all zero at all times. The layout is bit 0 gear-down (0 = half rate), bit 1 per-device addressing, bit 2 maximum power saving, bits 5:3 CS-to-command latency and bits 8:6 CA parity latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Controller reset, active low |
| pwr_good | input | 1 | Supplies stable; high starts the sequence, low aborts it |
| rtt_nom_en | input | 1 | Nominal termination will be enabled in mode register 1 |
| odt_park | input | 1 | ODT level wanted during init when nominal termination is off |
| mem_reset_n | output | 1 | Memory reset pin, active low |
| mem_ck_en | output | 1 | Enables the memory clock driver |
| mem_cke | output | 1 | Memory clock-enable pin |
| mem_odt | output | 1 | Memory on-die-termination pin |
| cmd_deselect | output | 1 | Command bus is driving deselect |
| init_done | output | 1 | Initialization complete |
| phase | output | 3 | Current phase code (see R1) |
| mr_dflt | output | 9 | Reset-time mode-register defaults (layout in R10) |

## Verification
Two events can land on the same edge: a power-good drop (R9) and a phase timer expiring into the next phase, which may be the ODT capture (R8) or the rise of clock-enable (R3). The bench repeats power-up and drops power-good after every possible number of cycles from the first cycle to past ready. Each offset therefore meets every phase boundary, including the edge that would have raised clock-enable and latched ODT. After each drop it checks that the abort wins and that every pin is back at its off value one cycle later.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  typedef enum logic [2:0] {
    PH_OFF       = 3'd0,
    PH_RST_HOLD  = 3'd1,
    PH_POST_RST  = 3'd2,
    PH_CLK_STAB  = 3'd3,
    PH_INIT_WAIT = 3'd4,
    PH_READY     = 3'd5
  } init_phase_e;

  // Bit 0 is gear_down; fields packed upward.
  typedef struct packed {
    logic [2:0] ca_par_lat;
    logic [2:0] cs_cmd_lat;
    logic       max_pwr_save;
    logic       per_dev_addr;
    logic       gear_down;
  } mr_dflt_t;

  localparam mr_dflt_t MR_RESET_DEFAULT = '0;

  function automatic longint cdiv(longint num, longint den);
    return (num + den - 1) / den;
  endfunction

  function automatic longint lmax(longint a, longint b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_phase_timer.sv
module init_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/init_phase_fsm.sv
module init_phase_fsm
  import dram_init_pkg::*;
#(
  parameter int CW     = 8,
  parameter int N_RST  = 4,
  parameter int N_POST = 4,
  parameter int N_STAB = 5,
  parameter int N_INIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          expired,
  output init_phase_e   phase_q,
  output init_phase_e   phase_d,
  output logic          load,
  output logic [CW-1:0] load_val
);

  localparam logic [CW-1:0] L_RST  = CW'(N_RST - 1);
  localparam logic [CW-1:0] L_POST = CW'(N_POST - 1);
  localparam logic [CW-1:0] L_STAB = CW'(N_STAB - 1);
  localparam logic [CW-1:0] L_INIT = CW'(N_INIT - 1);

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    if (!pwr_good) begin
      phase_d = PH_OFF;
    end else begin
      unique case (phase_q)
        PH_OFF: begin
          phase_d  = PH_RST_HOLD;
          load     = 1'b1;
          load_val = L_RST;
        end
        PH_RST_HOLD: if (expired) begin
          phase_d  = PH_POST_RST;
          load     = 1'b1;
          load_val = L_POST;
        end
        PH_POST_RST: if (expired) begin
          phase_d  = PH_CLK_STAB;
          load     = 1'b1;
          load_val = L_STAB;
        end
        PH_CLK_STAB: if (expired) begin
          phase_d  = PH_INIT_WAIT;
          load     = 1'b1;
          load_val = L_INIT;
        end
        PH_INIT_WAIT: if (expired) begin
          phase_d = PH_READY;
        end
        PH_READY: phase_d = PH_READY;
        default:  phase_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
    end else begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/init_pin_map.sv
module init_pin_map
  import dram_init_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  init_phase_e phase_q,
  input  init_phase_e phase_d,
  input  logic        rtt_nom_en,
  input  logic        odt_park,
  output logic        mem_reset_n,
  output logic        mem_ck_en,
  output logic        mem_cke,
  output logic        mem_odt,
  output logic        cmd_deselect,
  output logic        init_done
);

  logic odt_q;

  // ODT is latched once, on the edge that raises clock-enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odt_q <= 1'b0;
    end else if (phase_d == PH_OFF) begin
      odt_q <= 1'b0;
    end else if (phase_q == PH_CLK_STAB && phase_d == PH_INIT_WAIT) begin
      odt_q <= odt_park & ~rtt_nom_en;
    end
  end

  always_comb begin
    mem_reset_n  = 1'b0;
    mem_ck_en    = 1'b0;
    mem_cke      = 1'b0;
    cmd_deselect = 1'b0;
    init_done    = 1'b0;
    unique case (phase_q)
      PH_POST_RST: mem_reset_n = 1'b1;
      PH_CLK_STAB: begin
        mem_reset_n  = 1'b1;
        mem_ck_en    = 1'b1;
        cmd_deselect = 1'b1;
      end
      PH_INIT_WAIT: begin
        mem_reset_n  = 1'b1;
        mem_ck_en    = 1'b1;
        mem_cke      = 1'b1;
        cmd_deselect = 1'b1;
      end
      PH_READY: begin
        mem_reset_n = 1'b1;
        mem_ck_en   = 1'b1;
        mem_cke     = 1'b1;
        init_done   = 1'b1;
      end
      default: ;
    endcase
  end

  assign mem_odt = odt_q;

endmodule

// File: rtl/dram_pwrup_seq.sv
module dram_pwrup_seq
  import dram_init_pkg::*;
#(
  parameter int unsigned CLK_PS      = 4000,
  parameter int unsigned RST_HOLD_NS = 200000,
  parameter int unsigned POST_RST_NS = 500000,
  parameter int unsigned CK_STAB_NS  = 10,
  parameter int unsigned CK_STAB_MIN = 5,
  parameter int unsigned DLLK_CYC    = 768,
  parameter int unsigned ZQINIT_CYC  = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       rtt_nom_en,
  input  logic       odt_park,
  output logic       mem_reset_n,
  output logic       mem_ck_en,
  output logic       mem_cke,
  output logic       mem_odt,
  output logic       cmd_deselect,
  output logic       init_done,
  output logic [2:0] phase,
  output logic [8:0] mr_dflt
);

  localparam int N_RST  = int'(lmax(cdiv(longint'(RST_HOLD_NS) * 1000, longint'(CLK_PS)), 1));
  localparam int N_POST = int'(lmax(cdiv(longint'(POST_RST_NS) * 1000, longint'(CLK_PS)), 1));
  localparam int N_STAB = int'(lmax(lmax(cdiv(longint'(CK_STAB_NS) * 1000, longint'(CLK_PS)),
                                         longint'(CK_STAB_MIN)), 1));
  localparam int N_INIT = int'(lmax(lmax(longint'(DLLK_CYC), longint'(ZQINIT_CYC)), 1));
  localparam int N_MAX  = int'(lmax(lmax(N_RST, N_POST), lmax(N_STAB, N_INIT)));
  localparam int CW     = $clog2(N_MAX + 1);

  init_phase_e   phase_q;
  init_phase_e   phase_d;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;

  init_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  init_phase_fsm #(
    .CW(CW), .N_RST(N_RST), .N_POST(N_POST), .N_STAB(N_STAB), .N_INIT(N_INIT)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .expired  (tmr_expired),
    .phase_q  (phase_q),
    .phase_d  (phase_d),
    .load     (tmr_load),
    .load_val (tmr_val)
  );

  init_pin_map u_pins (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_q      (phase_q),
    .phase_d      (phase_d),
    .rtt_nom_en   (rtt_nom_en),
    .odt_park     (odt_park),
    .mem_reset_n  (mem_reset_n),
    .mem_ck_en    (mem_ck_en),
    .mem_cke      (mem_cke),
    .mem_odt      (mem_odt),
    .cmd_deselect (cmd_deselect),
    .init_done    (init_done)
  );

  assign phase   = phase_q;
  assign mr_dflt = MR_RESET_DEFAULT;

endmodule

// File: rtl/dram_pwrup_seq_chk.sv
module dram_pwrup_seq_chk #(
  parameter int N_RST  = 1,
  parameter int N_STAB = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_good,
  input logic       rtt_nom_en,
  input logic [2:0] phase,
  input logic       mem_reset_n,
  input logic       mem_ck_en,
  input logic       mem_cke,
  input logic       mem_odt,
  input logic       cmd_deselect,
  input logic       init_done
);

  int unsigned hold_cnt;
  int unsigned stab_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= 0;
      stab_cnt <= 0;
    end else begin
      hold_cnt <= (phase == 3'd1) ? hold_cnt + 1 : 0;
      stab_cnt <= (phase == 3'd3) ? stab_cnt + 1 : 0;
    end
  end

  AST_CKE_NEEDS_RESET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_reset_n |-> !mem_cke); // R3
  AST_RESET_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_reset_n) |-> hold_cnt == N_RST); // R2
  AST_CLK_SETTLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) |-> stab_cnt == N_STAB && mem_ck_en); // R5
  AST_DESEL_AT_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) |-> cmd_deselect); // R6
  AST_CKE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cke && pwr_good) |=> mem_cke); // R7
  AST_DONE_WITH_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> mem_cke && mem_reset_n && !cmd_deselect); // R7
  AST_ODT_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cke && pwr_good) |=> $stable(mem_odt)); // R8
  AST_ODT_LOW_FOR_RTT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) |-> !($past(rtt_nom_en) && mem_odt)); // R8
  AST_ABORT_ON_PG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> phase == 3'd0 && !mem_reset_n && !init_done && !mem_odt); // R9

endmodule

bind dram_pwrup_seq dram_pwrup_seq_chk #(.N_RST(N_RST), .N_STAB(N_STAB)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_good     (pwr_good),
  .rtt_nom_en   (rtt_nom_en),
  .phase        (phase),
  .mem_reset_n  (mem_reset_n),
  .mem_ck_en    (mem_ck_en),
  .mem_cke      (mem_cke),
  .mem_odt      (mem_odt),
  .cmd_deselect (cmd_deselect),
  .init_done    (init_done)
);

// File: tb/dram_pwrup_seq_bench.sv
module dram_pwrup_seq_bench;

  localparam int unsigned T_CLK_PS = 4000;
  localparam int unsigned T_RST_NS = 38;
  localparam int unsigned T_POST_NS = 58;
  localparam int unsigned T_STAB_NS = 26;
  localparam int unsigned T_STAB_MIN = 5;
  localparam int unsigned T_DLLK = 7;
  localparam int unsigned T_ZQ = 12;

  // Expected cycle counts, worked out from the requirements.
  localparam int E_RST  = (T_RST_NS * 1000 + T_CLK_PS - 1) / T_CLK_PS;
  localparam int E_POST = (T_POST_NS * 1000 + T_CLK_PS - 1) / T_CLK_PS;
  localparam int E_STQ  = (T_STAB_NS * 1000 + T_CLK_PS - 1) / T_CLK_PS;
  localparam int E_STAB = (E_STQ > int'(T_STAB_MIN)) ? E_STQ : int'(T_STAB_MIN);
  localparam int E_INIT = (T_DLLK > T_ZQ) ? int'(T_DLLK) : int'(T_ZQ);
  localparam int E_CAP  = E_RST + E_POST + E_STAB + 1;
  localparam int E_TOT  = E_RST + E_POST + E_STAB + E_INIT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic rtt_nom_en = 1'b0;
  logic odt_park = 1'b0;
  logic mem_reset_n, mem_ck_en, mem_cke, mem_odt, cmd_deselect, init_done;
  logic [2:0] phase;
  logic [8:0] mr_dflt;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2ns clk = ~clk;

  dram_pwrup_seq #(
    .CLK_PS(T_CLK_PS), .RST_HOLD_NS(T_RST_NS), .POST_RST_NS(T_POST_NS),
    .CK_STAB_NS(T_STAB_NS), .CK_STAB_MIN(T_STAB_MIN),
    .DLLK_CYC(T_DLLK), .ZQINIT_CYC(T_ZQ)
  ) u_dram_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .rtt_nom_en(rtt_nom_en),
    .odt_park(odt_park), .mem_reset_n(mem_reset_n), .mem_ck_en(mem_ck_en),
    .mem_cke(mem_cke), .mem_odt(mem_odt), .cmd_deselect(cmd_deselect),
    .init_done(init_done), .phase(phase), .mr_dflt(mr_dflt)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=60000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check_eq(string req, string what, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // Phase expected after e edges since power-good was first sampled high.
  function automatic int exp_phase(int e);
    if (e <= 0) return 0;
    if (e <= E_RST) return 1;
    if (e <= E_RST + E_POST) return 2;
    if (e <= E_RST + E_POST + E_STAB) return 3;
    if (e <= E_TOT) return 4;
    return 5;
  endfunction

  task automatic check_all(string tag, int e, bit cap_odt);
    int ph;
    ph = exp_phase(e);
    check_eq({tag, " R1"}, "phase", int'(phase), ph);
    check_eq({tag, " R2"}, "mem_reset_n", int'(mem_reset_n), int'(ph >= 2));
    check_eq({tag, " R3"}, "mem_cke", int'(mem_cke), int'(ph >= 4));
    check_eq({tag, " R4"}, "post-reset ck_en", int'(ph == 2 && mem_ck_en), 0);
    check_eq({tag, " R5"}, "mem_ck_en", int'(mem_ck_en), int'(ph >= 3));
    check_eq({tag, " R6"}, "cmd_deselect", int'(cmd_deselect), int'(ph == 3 || ph == 4));
    check_eq({tag, " R7"}, "init_done", int'(init_done), int'(ph == 5));
    check_eq({tag, " R8"}, "mem_odt", int'(mem_odt), (ph >= 4) ? int'(cap_odt) : 0);
    check_eq({tag, " R10"}, "mr_dflt", int'(mr_dflt), 0);
  endtask

  // Power up, run len edges, then drop power-good (R9).
  task automatic power_run(int len, bit rtt, bit park);
    bit cap;
    cap = park & ~rtt;
    pwr_good = 1'b1;
    rtt_nom_en = rtt;
    odt_park = park;
    for (int e = 1; e <= len; e++) begin
      @(negedge clk);
      check_all("run", e, cap);
      if (e >= E_CAP) begin
        rtt_nom_en = ~rtt_nom_en;   // R8: later input changes must not move ODT
        odt_park = ~odt_park;
      end
    end
    pwr_good = 1'b0;
    @(negedge clk);
    check_all("abort R9", 0, 1'b0);
    @(negedge clk);
    check_all("idle R9", 0, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    check_all("in-reset", 0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_all("pg-low", 0, 1'b0);
    end
    // Full runs across all termination settings, holding ready a while.
    for (int c = 0; c < 4; c++) begin
      power_run(E_TOT + 8, c[0], c[1]);
    end
    // Abort at every possible offset, including every phase boundary.
    for (int d = 1; d <= E_TOT + 3; d++) begin
      power_run(d, d[1], d[0] | d[2]);
    end
    summary();
    $finish;
  end

endmodule